// File: doc/BRIEF.md
# Predicate Guard Unit

This block holds the one-bit condition flags of a wide-issue datapath and decides, for every operation in an issue group, whether that operation may leave any trace. Compare operations produce a pair of flags in a single step: one flag receives the equality result and the other receives its inverse. Every issued operation carries the index of one flag as its guard. When the guard reads as zero, the unit drops the operation's register-file and memory write enables and raises a per-slot kill signal. The operation still travels through the pipeline, but it has no effect.

Each issue slot looks up its own guard independently. Because of this, the two arms of an if/else can be guarded by complementary flags and issued in the same group, and exactly one arm survives. Flag 0 is wired to one, so an operation that names index 0 is unconditional. Updates from compares become visible to guards one cycle after the compare. When several compares in one cycle target the same flag, the highest-numbered compare port wins.

Top module: `pred_guard_unit`

## Requirements
- R1: The unit holds NUM_PRED (default 64) one-bit flags. After reset, flags 1 to 63 read 0, so a valid guarded operation that names any of them is killed.
- R2: Flag 0 always reads 1 and ignores every compare write that names it. A valid operation guarded by index 0 is never killed.
- R3: A valid compare on port j writes the inverse of `cmp_eq_i[j]` into flag `cmp_pf_i[j]` and writes `cmp_eq_i[j]` into flag `cmp_pt_i[j]`, both on the same clock edge.
- R4: A flag written by a compare at the edge that closes cycle N is first seen by guards in cycle N+1. A guard that reads the same flag in cycle N sees the old value, because there is no bypass.
- R5: For slot s, `kill_o[s]` = `iss_vld_i[s]` AND NOT flag[guard]. `rf_we_o[s]` = `iss_vld_i[s]` AND `iss_rf_we_i[s]` AND flag[guard]. `mem_we_o[s]` follows the same rule with `iss_mem_we_i[s]`. All three are combinational in the current cycle.
- R6: All NUM_SLOTS (default 6) slots are evaluated in parallel against their own guard indices. Two slots guarded by complementary flags in one group give exactly one kill.
- R7: A valid compare whose two destination indices are equal writes only the equality result into that flag. It raises `cmp_err_o[j]` combinationally in the same cycle. Otherwise `cmp_err_o[j]` is 0.
- R8: When compare ports in one cycle write the same flag, the highest-numbered port decides its value. Within one port, the `cmp_pt_i` write takes precedence over the `cmp_pf_i` write.
- R9: A flag that no valid compare names in a cycle keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_vld_i | input | NUM_CMP | Compare port carries a result this cycle |
| cmp_eq_i | input | NUM_CMP | Equality outcome of each compare |
| cmp_pf_i | input | NUM_CMP*IDX_W | Destination flag for the inverted outcome, per compare |
| cmp_pt_i | input | NUM_CMP*IDX_W | Destination flag for the direct outcome, per compare |
| iss_vld_i | input | NUM_SLOTS | Slot holds an issued operation |
| iss_guard_i | input | NUM_SLOTS*IDX_W | Guard flag index per slot |
| iss_rf_we_i | input | NUM_SLOTS | Register write requested by the slot's operation |
| iss_mem_we_i | input | NUM_SLOTS | Memory write requested by the slot's operation |
| kill_o | output | NUM_SLOTS | Slot's operation is nullified |
| rf_we_o | output | NUM_SLOTS | Register write enable after guarding |
| mem_we_o | output | NUM_SLOTS | Memory write enable after guarding |
| cmp_err_o | output | NUM_CMP | Compare named one flag for both outcomes |

## Verification
The assertions assume three things about the inputs. Every index is legal, which holds because NUM_PRED is forced to a power of two and so every IDX_W-bit code names a flag. Inputs are stable around the rising edge. The highest compare port is never overridden by another writer. The bench changes inputs only on the falling edge. It draws indices from the full 0..63 range and, half of the time, from a small pool. The small pool makes compares collide with each other, with flag 0 and with same-cycle guard reads often enough to exercise the priority and no-bypass rules.

// File: rtl/pgu_pkg.sv
package pgu_pkg;
   localparam int PGU_NUM_PRED_DEF  = 64;
   localparam int PGU_NUM_SLOTS_DEF = 6;
   localparam int PGU_NUM_CMP_DEF   = 2;

   function automatic bit pgu_is_pow2(input int v);
      return (v > 1) && ((v & (v - 1)) == 0);
   endfunction
endpackage

// File: rtl/pgu_wr_merge.sv
module pgu_wr_merge #(
   parameter int NUM_PRED = 64,
   parameter int NUM_CMP  = 2,
   parameter int IDX_W    = $clog2(NUM_PRED)
) (
   input  logic [NUM_CMP-1:0]            cmp_vld_i,
   input  logic [NUM_CMP-1:0]            cmp_eq_i,
   input  logic [NUM_CMP-1:0][IDX_W-1:0] cmp_pf_i,
   input  logic [NUM_CMP-1:0][IDX_W-1:0] cmp_pt_i,
   output logic [NUM_PRED-1:0]           wr_en_o,
   output logic [NUM_PRED-1:0]           wr_val_o,
   output logic [NUM_CMP-1:0]            cmp_err_o
);
   // R8: later ports overwrite earlier ones; pt overwrites pf within a port (R7)
   always_comb begin
      wr_en_o  = '0;
      wr_val_o = '0;
      for (int j = 0; j < NUM_CMP; j++) begin
         if (cmp_vld_i[j]) begin
            wr_en_o[cmp_pf_i[j]]  = 1'b1;
            wr_val_o[cmp_pf_i[j]] = ~cmp_eq_i[j];
            wr_en_o[cmp_pt_i[j]]  = 1'b1;
            wr_val_o[cmp_pt_i[j]] = cmp_eq_i[j];
         end
      end
   end

   for (genvar j = 0; j < NUM_CMP; j++) begin : g_err
      assign cmp_err_o[j] = cmp_vld_i[j] && (cmp_pf_i[j] == cmp_pt_i[j]);
   end
endmodule

// File: rtl/pgu_regfile.sv
module pgu_regfile #(
   parameter int NUM_PRED = 64
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PRED-1:0] wr_en_i,
   input  logic [NUM_PRED-1:0] wr_val_i,
   output logic [NUM_PRED-1:0] pred_q
);
   for (genvar k = 0; k < NUM_PRED; k++) begin : g_flag
      if (k == 0) begin : g_const
         // R2: hardwired true, write enable for index 0 is dropped
         logic unused_wr;
         assign unused_wr = wr_en_i[0] ^ wr_val_i[0];
         assign pred_q[0] = 1'b1;
      end else begin : g_store
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               pred_q[k] <= 1'b0;
            else if (wr_en_i[k])
               pred_q[k] <= wr_val_i[k];
         end
      end
   end
endmodule

// File: rtl/pgu_slot_guard.sv
module pgu_slot_guard #(
   parameter int NUM_PRED = 64,
   parameter int IDX_W    = $clog2(NUM_PRED)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [NUM_PRED-1:0] pred_i,
   input  logic                vld_i,
   input  logic [IDX_W-1:0]    guard_i,
   input  logic                rf_we_i,
   input  logic                mem_we_i,
   output logic                kill_o,
   output logic                rf_we_o,
   output logic                mem_we_o
);
   logic pass;

   assign pass     = pred_i[guard_i];
   assign kill_o   = vld_i && !pass;
   assign rf_we_o  = vld_i && pass && rf_we_i;
   assign mem_we_o = vld_i && pass && mem_we_i;

   // R2
   p0_never_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (vld_i && guard_i == '0) |-> !kill_o);

   // R5
   kill_blocks_we_chk: assert property (@(posedge clk) disable iff (!rst_n)
      kill_o |-> (!rf_we_o && !mem_we_o));
endmodule

// File: rtl/pred_guard_unit.sv
module pred_guard_unit
   import pgu_pkg::*;
#(
   parameter int NUM_PRED  = PGU_NUM_PRED_DEF,
   parameter int NUM_SLOTS = PGU_NUM_SLOTS_DEF,
   parameter int NUM_CMP   = PGU_NUM_CMP_DEF,
   localparam int IDX_W    = $clog2(NUM_PRED)
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [NUM_CMP-1:0]                cmp_vld_i,
   input  logic [NUM_CMP-1:0]                cmp_eq_i,
   input  logic [NUM_CMP-1:0][IDX_W-1:0]     cmp_pf_i,
   input  logic [NUM_CMP-1:0][IDX_W-1:0]     cmp_pt_i,
   input  logic [NUM_SLOTS-1:0]              iss_vld_i,
   input  logic [NUM_SLOTS-1:0][IDX_W-1:0]   iss_guard_i,
   input  logic [NUM_SLOTS-1:0]              iss_rf_we_i,
   input  logic [NUM_SLOTS-1:0]              iss_mem_we_i,
   output logic [NUM_SLOTS-1:0]              kill_o,
   output logic [NUM_SLOTS-1:0]              rf_we_o,
   output logic [NUM_SLOTS-1:0]              mem_we_o,
   output logic [NUM_CMP-1:0]                cmp_err_o
);
   localparam int LAST = NUM_CMP - 1;

   if (!pgu_is_pow2(NUM_PRED)) begin : g_bad_pred
      $error("NUM_PRED must be a power of two of at least 2");
   end
   if (NUM_SLOTS < 1) begin : g_bad_slots
      $error("NUM_SLOTS must be at least 1");
   end
   if (NUM_CMP < 1) begin : g_bad_cmp
      $error("NUM_CMP must be at least 1");
   end

   logic [NUM_PRED-1:0] wr_en;
   logic [NUM_PRED-1:0] wr_val;
   logic [NUM_PRED-1:0] pred_q;

   pgu_wr_merge #(.NUM_PRED(NUM_PRED), .NUM_CMP(NUM_CMP), .IDX_W(IDX_W)) u_merge (
      .cmp_vld_i (cmp_vld_i),
      .cmp_eq_i  (cmp_eq_i),
      .cmp_pf_i  (cmp_pf_i),
      .cmp_pt_i  (cmp_pt_i),
      .wr_en_o   (wr_en),
      .wr_val_o  (wr_val),
      .cmp_err_o (cmp_err_o)
   );

   pgu_regfile #(.NUM_PRED(NUM_PRED)) u_file (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en_i  (wr_en),
      .wr_val_i (wr_val),
      .pred_q   (pred_q)
   );

   for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
      pgu_slot_guard #(.NUM_PRED(NUM_PRED), .IDX_W(IDX_W)) u_guard (
         .clk      (clk),
         .rst_n    (rst_n),
         .pred_i   (pred_q),
         .vld_i    (iss_vld_i[s]),
         .guard_i  (iss_guard_i[s]),
         .rf_we_i  (iss_rf_we_i[s]),
         .mem_we_i (iss_mem_we_i[s]),
         .kill_o   (kill_o[s]),
         .rf_we_o  (rf_we_o[s]),
         .mem_we_o (mem_we_o[s])
      );
   end

   // R3 R8: the top port's direct outcome lands one cycle later
   last_pt_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_vld_i[LAST] && cmp_pt_i[LAST] != '0)
      |=> pred_q[$past(cmp_pt_i[LAST])] == $past(cmp_eq_i[LAST]));

   // R3
   last_pf_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_vld_i[LAST] && cmp_pf_i[LAST] != '0 && cmp_pf_i[LAST] != cmp_pt_i[LAST])
      |=> pred_q[$past(cmp_pf_i[LAST])] == !$past(cmp_eq_i[LAST]));

   // R9
   idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (cmp_vld_i == '0) |=> $stable(pred_q));

   // R2
   p0_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pred_q[0]);
endmodule

// File: tb/pred_guard_unit_tb.sv
module pred_guard_unit_tb;
   localparam int NP = 64;
   localparam int NS = 6;
   localparam int NC = 2;
   localparam int IW = 6;

   logic clk = 1'b0;
   always #2 clk = ~clk;

   logic                      rst_n;
   logic [NC-1:0]             cmp_vld, cmp_eq, cmp_err;
   logic [NC-1:0][IW-1:0]     cmp_pf, cmp_pt;
   logic [NS-1:0]             iss_vld, iss_rf, iss_mem, kill, rf_we, mem_we;
   logic [NS-1:0][IW-1:0]     iss_guard;

   bit model [NP];
   int n_chk = 0;
   int n_bad = 0;

   pred_guard_unit u_dut (
      .clk (clk), .rst_n (rst_n),
      .cmp_vld_i (cmp_vld), .cmp_eq_i (cmp_eq), .cmp_pf_i (cmp_pf), .cmp_pt_i (cmp_pt),
      .iss_vld_i (iss_vld), .iss_guard_i (iss_guard),
      .iss_rf_we_i (iss_rf), .iss_mem_we_i (iss_mem),
      .kill_o (kill), .rf_we_o (rf_we), .mem_we_o (mem_we), .cmp_err_o (cmp_err)
   );

   task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic idle();
      cmp_vld = '0; cmp_eq = '0; cmp_pf = '0; cmp_pt = '0;
      iss_vld = '0; iss_guard = '0; iss_rf = '0; iss_mem = '0;
   endtask

   task automatic apply_model();
      for (int j = 0; j < NC; j++) begin
         if (cmp_vld[j]) begin
            if (cmp_pf[j] != 0) model[cmp_pf[j]] = !cmp_eq[j];
            if (cmp_pt[j] != 0) model[cmp_pt[j]] = cmp_eq[j];
         end
      end
   endtask

   task automatic check_outputs(input string req);
      for (int s = 0; s < NS; s++) begin
         bit g;
         g = model[iss_guard[s]];
         chk(req, $sformatf("kill[%0d]", s), 32'(kill[s]), 32'(iss_vld[s] && !g));
         chk(req, $sformatf("rf_we[%0d]", s), 32'(rf_we[s]), 32'(iss_vld[s] && iss_rf[s] && g));
         chk(req, $sformatf("mem_we[%0d]", s), 32'(mem_we[s]), 32'(iss_vld[s] && iss_mem[s] && g));
      end
      for (int j = 0; j < NC; j++)
         chk("R7", $sformatf("cmp_err[%0d]", j), 32'(cmp_err[j]),
             32'(cmp_vld[j] && cmp_pf[j] == cmp_pt[j]));
   endtask

   // inputs already set at a falling edge; check, clock them in, return at next falling edge
   task automatic step(input string req);
      #1 check_outputs(req);
      @(posedge clk);
      apply_model();
      @(negedge clk);
   endtask

   task automatic probe(input string req, input int k, input bit expv);
      idle();
      iss_vld[0] = 1'b1; iss_guard[0] = IW'(k); iss_rf[0] = 1'b1; iss_mem[0] = 1'b1;
      #1 chk(req, $sformatf("kill on flag %0d", k), 32'(kill[0]), 32'(!expv));
      @(negedge clk);
   endtask

   task automatic set_cmp(input int j, input int pf, input int pt, input bit eq);
      cmp_vld[j] = 1'b1; cmp_pf[j] = IW'(pf); cmp_pt[j] = IW'(pt); cmp_eq[j] = eq;
   endtask

   function automatic logic [IW-1:0] pick_idx();
      if ($urandom % 2) return IW'($urandom % 8);
      return IW'($urandom % NP);
   endfunction

   initial begin
      repeat (200000) @(posedge clk);
      n_bad++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end

   initial begin
      void'($urandom(32'd4242));
      for (int k = 0; k < NP; k++) model[k] = (k == 0);
      rst_n = 1'b0;
      idle();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state of every flag, R2: flag 0 is true
      for (int k = 1; k < NP; k++) probe("R1", k, 1'b0);
      probe("R2", 0, 1'b1);

      // R3: complementary pair, both senses
      idle(); set_cmp(0, 3, 4, 1'b0); step("R3");
      probe("R3", 3, 1'b1); probe("R3", 4, 1'b0);
      idle(); set_cmp(0, 3, 4, 1'b1); step("R3");
      probe("R3", 3, 1'b0); probe("R3", 4, 1'b1);

      // R4: guard reads old value of a flag written the same cycle
      idle(); set_cmp(0, 4, 5, 1'b1);
      iss_vld[1] = 1'b1; iss_guard[1] = 6'd4; iss_rf[1] = 1'b1;
      #1 chk("R4", "same-cycle kill[1]", 32'(kill[1]), 32'd0);
      step("R4");
      probe("R4", 4, 1'b0); probe("R4", 5, 1'b1);

      // R2: writes aimed at flag 0 are dropped in either sense
      idle(); set_cmp(0, 0, 6, 1'b1); step("R2");
      probe("R2", 0, 1'b1); probe("R2", 6, 1'b1);
      idle(); set_cmp(1, 7, 0, 1'b0); step("R2");
      probe("R2", 0, 1'b1); probe("R2", 7, 1'b1);

      // R6: if/else arms issued together on complementary flags
      idle(); set_cmp(0, 20, 21, 1'b1); step("R6");
      idle();
      iss_vld[2] = 1'b1; iss_guard[2] = 6'd20; iss_rf[2] = 1'b1; iss_mem[2] = 1'b1;
      iss_vld[3] = 1'b1; iss_guard[3] = 6'd21; iss_rf[3] = 1'b1; iss_mem[3] = 1'b1;
      #1;
      chk("R6", "kill[2]", 32'(kill[2]), 32'd1);
      chk("R6", "kill[3]", 32'(kill[3]), 32'd0);
      chk("R6", "rf_we[2]", 32'(rf_we[2]), 32'd0);
      chk("R6", "rf_we[3]", 32'(rf_we[3]), 32'd1);
      @(negedge clk);

      // R5: invalid slot gives nothing; guarded slot passes only requested enables
      idle();
      iss_vld[4] = 1'b0; iss_guard[4] = 6'd21; iss_rf[4] = 1'b1; iss_mem[4] = 1'b1;
      iss_vld[5] = 1'b1; iss_guard[5] = 6'd21; iss_rf[5] = 1'b0; iss_mem[5] = 1'b1;
      #1;
      chk("R5", "kill[4]", 32'(kill[4]), 32'd0);
      chk("R5", "rf_we[4]", 32'(rf_we[4]), 32'd0);
      chk("R5", "rf_we[5]", 32'(rf_we[5]), 32'd0);
      chk("R5", "mem_we[5]", 32'(mem_we[5]), 32'd1);
      @(negedge clk);

      // R7: same flag named twice, direct outcome written
      idle(); set_cmp(0, 9, 9, 1'b1);
      #1 chk("R7", "cmp_err[0]", 32'(cmp_err[0]), 32'd1);
      step("R7");
      probe("R7", 9, 1'b1);
      idle(); set_cmp(1, 9, 9, 1'b0); step("R7");
      probe("R7", 9, 1'b0);

      // R8: higher port wins on a shared flag
      idle(); set_cmp(0, 11, 10, 1'b1); set_cmp(1, 10, 12, 1'b1); step("R8");
      probe("R8", 10, 1'b0); probe("R8", 11, 1'b0); probe("R8", 12, 1'b1);
      idle(); set_cmp(0, 10, 13, 1'b1); set_cmp(1, 14, 10, 1'b1); step("R8");
      probe("R8", 10, 1'b1);

      // R9: untouched flags keep their values
      idle(); set_cmp(0, 30, 31, 1'b1); step("R9");
      probe("R9", 21, 1'b1); probe("R9", 20, 1'b0); probe("R9", 12, 1'b1);

      // random mix
      for (int n = 0; n < 4000; n++) begin
         idle();
         for (int j = 0; j < NC; j++) begin
            cmp_vld[j] = 1'($urandom % 2);
            cmp_eq[j]  = 1'($urandom % 2);
            cmp_pf[j]  = pick_idx();
            cmp_pt[j]  = ($urandom % 16 == 0) ? cmp_pf[j] : pick_idx();
         end
         for (int s = 0; s < NS; s++) begin
            iss_vld[s]   = 1'($urandom % 4 != 0);
            iss_guard[s] = pick_idx();
            iss_rf[s]    = 1'($urandom % 2);
            iss_mem[s]   = 1'($urandom % 2);
         end
         step("R5");
      end

      // R9: whole file agrees with the bench's record after the random run
      for (int k = 0; k < NP; k++) probe("R9", k, model[k]);

      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule